// File: doc/BRIEF.md
# Microcontroller Sleep and Wake-Up Sequencer

This block sequences power-down for a small 8-bit microcontroller core. When the core executes its sleep instruction it raises `sleep_req` for one cycle. The sequencer then updates the power-down and timeout status bits and clears the watchdog. If no enabled interrupt is already pending, it stops the oscillator driver and waits. It leaves sleep on one of three events. The external reset pin gives a full device reset. A watchdog timeout, when the watchdog is enabled, resumes in-line. An interrupt line whose own enable is set also resumes, whatever the global enable says.

In crystal-type oscillator modes, the sequencer holds the core in a start-up delay of `OST_CYCLES` oscillator periods after a wake. `ost_count` shows the delay as it counts. In RC mode the delay is skipped. At the end the sequencer pulses `resume`, which lets the core execute the instruction it prefetched after the sleep instruction. If the global enable was set when an interrupt woke the part, `vec_jump` follows one cycle later. That cycle is the dummy slot, in which the core loads the interrupt vector `vec_addr`.

All interfaces are plain control and status pins. The block carries no data stream, so it has no valid/ready handshake and no back-pressure.

Top module: `pwrdn_seq`

## Requirements
- R1: While `rst_n` is low and after it is released, `pd_bit`=1, `to_bit`=1, `osc_run`=1, `sleeping`=0, `ost_count`=0, and `wdt_clr`, `resume`, `vec_jump`, `wdt_rst` and `dev_reset` are all 0.
- R2: A `sleep_req` while running with no pending enabled interrupt produces the following in the next cycle: `sleeping`=1, `osc_run`=0, `pd_bit`=0, `to_bit`=1, and a one-cycle `wdt_clr`.
- R3: During sleep, interrupt line i wakes the part only when `irq_flag[i]` and `irq_en[i]` are both 1. A flag whose own enable is 0 leaves `sleeping`=1. The value of `gie` has no effect on whether a wake happens.
- R4: During sleep, `wdt_timeout` wakes the part only when `wdt_en`=1. Such a wake clears `to_bit` and never produces `vec_jump`.
- R5: `ext_rst_n` low in any state makes the next cycle show `dev_reset`=1, `sleeping`=0 and `osc_run`=1, with no later `resume`. It leaves `pd_bit` and `to_bit` unchanged. It takes priority over a simultaneous interrupt or watchdog timeout.
- R6: Every exit from sleep, whatever its cause, gives a one-cycle `wdt_clr` in the cycle after the wake event.
- R7: In crystal mode (`osc_rc`=0), a wake turns the oscillator back on in the next cycle. `ost_count` then steps 0,1,… once per cycle, and `sleeping` stays 1. `resume` pulses `OST_CYCLES` cycles after that first cycle, and `sleeping` drops with it. `ost_count` is held at 0 while asleep.
- R8: In RC mode (`osc_rc`=1), `resume` and `wdt_clr` pulse together in the cycle after the wake event, and no start-up count runs.
- R9: `vec_jump` pulses exactly one cycle after `resume` if and only if the wake came from an interrupt while `gie` was 1 at the wake event. Later changes of `gie` do not alter that choice. `vec_addr` equals `VEC_ADDR` (0x004 by default).
- R10: A `sleep_req` while any line already has flag and enable set wakes at once. The next cycle shows `pd_bit`=0, `to_bit`=1, `wdt_clr`=1 and `resume`=1, with `sleeping` and `osc_run` unchanged at 0 and 1. `vec_jump` follows if `gie`=1.
- R11: A watchdog timeout while running with `wdt_en`=1 gives a one-cycle `wdt_rst` in the next cycle, with `to_bit`=0 and `pd_bit`=1. It never raises `dev_reset`, which follows only the external pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Power-on reset, active low |
| ext_rst_n | input | 1 | External reset pin, active low |
| sleep_req | input | 1 | Sleep instruction executing, one-cycle strobe |
| wdt_en | input | 1 | Watchdog enabled |
| wdt_timeout | input | 1 | Watchdog timeout pulse |
| irq_flag | input | NUM_IRQ | Interrupt flags |
| irq_en | input | NUM_IRQ | Per-line interrupt enables |
| gie | input | 1 | Global interrupt enable |
| osc_rc | input | 1 | 1 = RC oscillator mode (no start-up delay) |
| osc_run | output | 1 | Oscillator driver enable |
| sleeping | output | 1 | High from sleep entry until start-up delay ends |
| pd_bit | output | 1 | Power-down status bit |
| to_bit | output | 1 | Timeout status bit |
| wdt_clr | output | 1 | Watchdog counter clear pulse |
| wdt_rst | output | 1 | Watchdog-caused device reset pulse |
| dev_reset | output | 1 | Device reset from the external pin |
| ost_count | output | CNT_W | Start-up delay counter |
| resume | output | 1 | Execute the prefetched next instruction |
| vec_jump | output | 1 | Dummy cycle plus branch to interrupt vector |
| vec_addr | output | PC_W | Interrupt vector address |

## Verification
The bench builds the sequencer with `OST_CYCLES`=16 and `NUM_IRQ`=3. The short delay lets the bench watch the start-up counter through every value up to expiry, then see the `resume` pulse and confirm it arrives on the exact cycle. Three lines give room to drive flags whose own enable is clear alongside enabled ones. The bench also covers immediate wake from a pending interrupt, a pin reset racing an interrupt and a watchdog timeout in the same cycle, and both oscillator modes.

// File: rtl/pwrdn_pkg.sv
package pwrdn_pkg;

  typedef enum logic [1:0] {
    PS_RUN   = 2'd0,
    PS_SLEEP = 2'd1,
    PS_OST   = 2'd2
  } pwr_state_t;

  typedef enum logic [1:0] {
    WK_NONE = 2'd0,
    WK_PIN  = 2'd1,
    WK_WDT  = 2'd2,
    WK_IRQ  = 2'd3
  } wake_src_t;

endpackage

// File: rtl/pwrdn_wake_eval.sv
module pwrdn_wake_eval
  import pwrdn_pkg::*;
#(
  parameter int NUM_IRQ = 3
) (
  input  logic               pin_low,
  input  logic               wdt_en,
  input  logic               wdt_timeout,
  input  logic [NUM_IRQ-1:0] irq_flag,
  input  logic [NUM_IRQ-1:0] irq_en,
  output wake_src_t          src,
  output logic               irq_hit
);

  logic [NUM_IRQ-1:0] line_hit;

  // Each line counts only when its own enable is set; global enable is not consulted.
  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
    assign line_hit[i] = irq_flag[i] & irq_en[i];
  end

  assign irq_hit = |line_hit;

  // Priority: external pin, then watchdog, then interrupts.
  always_comb begin
    if (pin_low)                   src = WK_PIN;
    else if (wdt_en && wdt_timeout) src = WK_WDT;
    else if (irq_hit)              src = WK_IRQ;
    else                           src = WK_NONE;
  end

endmodule

// File: rtl/pwrdn_ost_timer.sv
module pwrdn_ost_timer #(
  parameter  int CYCLES = 1024,
  localparam int W      = (CYCLES > 1) ? $clog2(CYCLES) : 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  output logic [W-1:0] count,
  output logic         done
);

  localparam logic [W-1:0] LAST = W'(CYCLES - 1);

  assign done = run && (count == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            count <= '0;
    else if (run && !done) count <= count + 1'b1;
    else                   count <= '0;
  end

endmodule

// File: rtl/pwrdn_resume_ctl.sv
module pwrdn_resume_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  logic use_vec,
  output logic resume,
  output logic vec_jump
);

  logic vec_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resume   <= 1'b0;
      vec_pend <= 1'b0;
      vec_jump <= 1'b0;
    end else begin
      resume   <= go;
      vec_pend <= go & use_vec;
      vec_jump <= resume & vec_pend;
    end
  end

endmodule

// File: rtl/pwrdn_seq.sv
module pwrdn_seq
  import pwrdn_pkg::*;
#(
  parameter  int NUM_IRQ    = 3,
  parameter  int OST_CYCLES = 1024,
  parameter  int PC_W       = 13,
  parameter  int VEC_ADDR   = 4,
  localparam int CNT_W      = (OST_CYCLES > 1) ? $clog2(OST_CYCLES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ext_rst_n,
  input  logic               sleep_req,
  input  logic               wdt_en,
  input  logic               wdt_timeout,
  input  logic [NUM_IRQ-1:0] irq_flag,
  input  logic [NUM_IRQ-1:0] irq_en,
  input  logic               gie,
  input  logic               osc_rc,
  output logic               osc_run,
  output logic               sleeping,
  output logic               pd_bit,
  output logic               to_bit,
  output logic               wdt_clr,
  output logic               wdt_rst,
  output logic               dev_reset,
  output logic [CNT_W-1:0]   ost_count,
  output logic               resume,
  output logic               vec_jump,
  output logic [PC_W-1:0]    vec_addr
);

  pwr_state_t state_q, state_d;
  wake_src_t  src;
  logic       irq_hit;
  logic       ost_done;
  logic       go, use_vec;
  logic       vec_q, vec_d;
  logic       clr_d;

  pwrdn_wake_eval #(.NUM_IRQ(NUM_IRQ)) u_eval (
    .pin_low     (!ext_rst_n),
    .wdt_en      (wdt_en),
    .wdt_timeout (wdt_timeout),
    .irq_flag    (irq_flag),
    .irq_en      (irq_en),
    .src         (src),
    .irq_hit     (irq_hit)
  );

  pwrdn_ost_timer #(.CYCLES(OST_CYCLES)) u_ost (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (state_q == PS_OST),
    .count (ost_count),
    .done  (ost_done)
  );

  pwrdn_resume_ctl u_resume (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (go),
    .use_vec  (use_vec),
    .resume   (resume),
    .vec_jump (vec_jump)
  );

  always_comb begin
    state_d = state_q;
    go      = 1'b0;
    use_vec = 1'b0;
    clr_d   = 1'b0;
    vec_d   = vec_q;
    case (state_q)
      PS_RUN: begin
        if (src != WK_PIN && sleep_req) begin
          clr_d = 1'b1;
          if (irq_hit) begin
            go      = 1'b1;
            use_vec = gie;
          end else begin
            state_d = PS_SLEEP;
          end
        end
      end
      PS_SLEEP: begin
        if (src != WK_NONE) begin
          clr_d = 1'b1;
          if (src == WK_PIN) begin
            state_d = PS_RUN;
          end else begin
            vec_d = (src == WK_IRQ) && gie;
            if (osc_rc) begin
              state_d = PS_RUN;
              go      = 1'b1;
              use_vec = vec_d;
            end else begin
              state_d = PS_OST;
            end
          end
        end
      end
      PS_OST: begin
        if (src == WK_PIN) begin
          state_d = PS_RUN;
        end else if (ost_done) begin
          state_d = PS_RUN;
          go      = 1'b1;
          use_vec = vec_q;
        end
      end
      default: state_d = PS_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= PS_RUN;
      vec_q     <= 1'b0;
      wdt_clr   <= 1'b0;
      wdt_rst   <= 1'b0;
      dev_reset <= 1'b0;
      pd_bit    <= 1'b1;
      to_bit    <= 1'b1;
    end else begin
      state_q   <= state_d;
      vec_q     <= vec_d;
      wdt_clr   <= clr_d;
      dev_reset <= !ext_rst_n;
      wdt_rst   <= (state_q == PS_RUN) && (src == WK_WDT) && !sleep_req;
      if (state_q == PS_RUN && src != WK_PIN) begin
        if (sleep_req) begin
          pd_bit <= 1'b0;
          to_bit <= 1'b1;
        end else if (src == WK_WDT) begin
          pd_bit <= 1'b1;
          to_bit <= 1'b0;
        end
      end else if (state_q == PS_SLEEP && src == WK_WDT) begin
        to_bit <= 1'b0;
      end
    end
  end

  assign osc_run  = (state_q != PS_SLEEP);
  assign sleeping = (state_q != PS_RUN);
  assign vec_addr = PC_W'(VEC_ADDR);

  AST_PIN_RESET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_rst_n |=> dev_reset && !sleeping && osc_run); // R5

  AST_SLEEP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_RUN && sleep_req && ext_rst_n && !irq_hit) |=> sleeping && !osc_run && !pd_bit && to_bit && wdt_clr); // R2

  AST_MASKED_STAYS_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_SLEEP && ext_rst_n && !(wdt_en && wdt_timeout) && (irq_flag & irq_en) == '0) |=> state_q == PS_SLEEP); // R3

  AST_IMMEDIATE_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_RUN && sleep_req && ext_rst_n && irq_hit) |=> resume && !sleeping && !pd_bit && wdt_clr); // R10

  AST_OST_IDLE_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_SLEEP) |-> ost_count == '0); // R7

  AST_OST_EXPIRY_RESUMES: assert property (@(posedge clk) disable iff (!rst_n)
    (ost_done && ext_rst_n) |=> resume && !sleeping); // R7

  AST_VEC_FOLLOWS_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
    vec_jump |-> $past(resume) && !sleeping); // R9

  AST_WDT_RST_NOT_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst |-> !dev_reset && !to_bit); // R11

endmodule

// File: tb/pwrdn_seq_bench.sv
`timescale 1ns/1ps
module pwrdn_seq_bench;

  localparam int NI   = 3;
  localparam int NOST = 16;
  localparam int CW   = 4;
  localparam logic [4:0] M_CLR  = 5'b00001;
  localparam logic [4:0] M_RES  = 5'b00010;
  localparam logic [4:0] M_VEC  = 5'b00100;
  localparam logic [4:0] M_WRST = 5'b01000;
  localparam logic [4:0] M_DRST = 5'b10000;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, ext_rst_n, sleep_req, wdt_en, wdt_timeout, gie, osc_rc;
  logic [NI-1:0] irq_flag, irq_en;
  logic osc_run, sleeping, pd_bit, to_bit, wdt_clr, wdt_rst, dev_reset, resume, vec_jump;
  logic [CW-1:0] ost_count;
  logic [12:0] vec_addr;

  pwrdn_seq #(.NUM_IRQ(NI), .OST_CYCLES(NOST)) u_pwrdn_seq (
    .clk(clk), .rst_n(rst_n), .ext_rst_n(ext_rst_n), .sleep_req(sleep_req),
    .wdt_en(wdt_en), .wdt_timeout(wdt_timeout), .irq_flag(irq_flag), .irq_en(irq_en),
    .gie(gie), .osc_rc(osc_rc), .osc_run(osc_run), .sleeping(sleeping),
    .pd_bit(pd_bit), .to_bit(to_bit), .wdt_clr(wdt_clr), .wdt_rst(wdt_rst),
    .dev_reset(dev_reset), .ost_count(ost_count), .resume(resume),
    .vec_jump(vec_jump), .vec_addr(vec_addr)
  );

  int cyc = 0;
  int checks = 0;
  int bad = 0;

  typedef struct {
    int         cyc;
    logic [4:0] mask;
    string      req;
  } exp_t;
  exp_t q[$];

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: compares the pulse outputs each cycle against the expected queue.
  always @(negedge clk) begin
    logic [4:0] obs;
    if (rst_n) begin
      obs = {dev_reset, wdt_rst, vec_jump, resume, wdt_clr};
      while (q.size() > 0 && q[0].cyc < cyc) begin
        checks++; bad++;
        $display("FAIL %s cycle %0d: actual=missed expected=%b", q[0].req, q[0].cyc, q[0].mask);
        void'(q.pop_front());
      end
      if (q.size() > 0 && q[0].cyc == cyc) begin
        checks++;
        if (obs !== q[0].mask) begin
          bad++;
          $display("FAIL %s cycle %0d: actual=%b expected=%b", q[0].req, cyc, obs, q[0].mask);
        end
        void'(q.pop_front());
      end else if (obs !== 5'b0) begin
        checks++; bad++;
        $display("FAIL R9 unexpected pulse cycle %0d: actual=%b expected=00000", cyc, obs);
      end
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic push(input int c, input logic [4:0] m, input string r);
    q.push_back('{c, m, r});
  endtask

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic go_sleep(input string r);
    push(cyc + 1, M_CLR, r);
    sleep_req = 1'b1;
    tick();
    sleep_req = 1'b0;
  endtask

  task automatic run_tests();
    int c;
    rst_n = 1'b0; ext_rst_n = 1'b1; sleep_req = 1'b0; wdt_en = 1'b0;
    wdt_timeout = 1'b0; gie = 1'b0; osc_rc = 1'b0; irq_flag = '0; irq_en = '0;
    repeat (3) tick();
    chk("R1 pd", pd_bit, 1); chk("R1 to", to_bit, 1); chk("R1 osc", osc_run, 1);
    rst_n = 1'b1;
    tick();
    chk("R1 sleeping", sleeping, 0); chk("R1 ost", ost_count, 0);
    chk("R1 pulses", {resume, vec_jump, wdt_clr, wdt_rst, dev_reset}, 0);

    // Crystal mode, interrupt wake with global enable set.
    osc_rc = 1'b0; gie = 1'b1; irq_en = 3'b001;
    go_sleep("R6");
    chk("R2 sleeping", sleeping, 1); chk("R2 osc", osc_run, 0);
    chk("R2 pd", pd_bit, 0); chk("R2 to", to_bit, 1); chk("R7 held", ost_count, 0);
    repeat (3) tick();
    irq_flag = 3'b110;
    tick(); tick();
    chk("R3 masked flags", sleeping, 1);
    c = cyc;
    irq_flag = 3'b111;
    push(c + 1, M_CLR, "R6");
    push(c + 1 + NOST, M_RES, "R7");
    push(c + 2 + NOST, M_VEC, "R9");
    tick();
    irq_flag = '0; gie = 1'b0;
    chk("R7 osc on", osc_run, 1); chk("R7 sleeping", sleeping, 1); chk("R7 cnt0", ost_count, 0);
    repeat (5) tick();
    chk("R7 cnt5", ost_count, 5);
    while (cyc < c + 1 + NOST) tick();
    chk("R7 awake", sleeping, 0);
    tick();
    chk("R9 vec_addr", vec_addr, 4);

    // RC mode: watchdog ignored when disabled, interrupt wake with gie clear.
    osc_rc = 1'b1; wdt_en = 1'b0; gie = 1'b0; irq_en = 3'b100;
    go_sleep("R2");
    wdt_timeout = 1'b1;
    tick();
    wdt_timeout = 1'b0;
    chk("R4 disabled wdt", sleeping, 1); chk("R4 to kept", to_bit, 1);
    c = cyc;
    irq_flag = 3'b100;
    push(c + 1, M_CLR | M_RES, "R8");
    tick();
    irq_flag = '0;
    chk("R8 awake", sleeping, 0); chk("R8 osc", osc_run, 1); chk("R8 cnt", ost_count, 0);
    tick(); tick();

    // RC mode: watchdog wake.
    wdt_en = 1'b1; gie = 1'b1; irq_en = '0;
    go_sleep("R2");
    c = cyc;
    wdt_timeout = 1'b1;
    push(c + 1, M_CLR | M_RES, "R4");
    tick();
    wdt_timeout = 1'b0;
    chk("R4 to cleared", to_bit, 0); chk("R4 awake", sleeping, 0);
    tick(); tick();
    wdt_en = 1'b0;

    // Immediate wake on pending interrupt.
    osc_rc = 1'b0; gie = 1'b1; irq_en = 3'b010; irq_flag = 3'b010;
    c = cyc;
    push(c + 1, M_CLR | M_RES, "R10");
    push(c + 2, M_VEC, "R10");
    sleep_req = 1'b1;
    tick();
    sleep_req = 1'b0; irq_flag = '0;
    chk("R10 pd", pd_bit, 0); chk("R10 to", to_bit, 1);
    chk("R10 sleeping", sleeping, 0); chk("R10 osc", osc_run, 1);
    tick(); tick();

    // Pin reset during sleep races an interrupt and a watchdog timeout.
    irq_en = 3'b001;
    go_sleep("R2");
    tick();
    c = cyc;
    ext_rst_n = 1'b0; irq_flag = 3'b001; wdt_en = 1'b1; wdt_timeout = 1'b1;
    push(c + 1, M_CLR | M_DRST, "R5");
    tick();
    ext_rst_n = 1'b1; irq_flag = '0; wdt_timeout = 1'b0; wdt_en = 1'b0;
    chk("R5 awake", sleeping, 0); chk("R5 osc", osc_run, 1);
    chk("R5 to kept", to_bit, 1); chk("R5 pd kept", pd_bit, 0);
    repeat (NOST + 4) tick();

    // Watchdog timeout while running.
    wdt_en = 1'b1;
    c = cyc;
    wdt_timeout = 1'b1;
    push(c + 1, M_WRST, "R11");
    tick();
    wdt_timeout = 1'b0; wdt_en = 1'b0;
    chk("R11 to", to_bit, 0); chk("R11 pd", pd_bit, 1); chk("R11 pin", dev_reset, 0);

    // Pin reset while running.
    c = cyc;
    ext_rst_n = 1'b0;
    push(c + 1, M_DRST, "R5");
    tick();
    ext_rst_n = 1'b1;
    chk("R5 run sleeping", sleeping, 0); chk("R5 run to", to_bit, 0);
    repeat (4) tick();
    chk("R9 queue drained", q.size(), 0);
  endtask

  initial begin
    fork
      run_tests();
      begin
        repeat (20000) @(posedge clk);
        checks++; bad++;
        $display("FAIL watchdog all: actual=hung expected=done");
      end
    join_any
    disable fork;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

endmodule